// File: doc/BRIEF.md
# Write-Only I2C Mode-Control Slave

This block is a bus slave for a two-wire serial control port that accepts only writes. It runs on a fast system clock and oversamples the bus clock and data lines. From the oversampled lines it finds the START and STOP conditions and shifts in an address byte and then a data byte, most significant bit first. The data line is driven only through an open-drain pull-down enable. The block pulls the line low to acknowledge a matching address and then to acknowledge the data byte that follows it.

The expected address is fixed except for one bit, which comes from an address-select pin. Two such parts can therefore share one bus. There is no sub-address byte: the top two bits of the data byte select the target register. Only the mode-control register exists. It drives a single-ended/differential select, an output-mode select and a 3-bit mode code. The system clock must run at least ten times faster than the bus clock, and the bus clock may run up to 400 kHz.

Top module: `i2c_mode_slave`

## Requirements
- R1: A synchronous active-low reset clears diff_sel, ocl_sel and mode_code to 0, releases sda_pull, and returns the slave to idle.
- R2: The slave acknowledges an address byte (sda_pull high, so the line is low during the ninth clock) only when it equals 1111_1 0 S 0, where S is addr_sel. That is 0xF8 with addr_sel=0 and 0xFA with addr_sel=1.
- R3: Any other address byte is not acknowledged, including one whose last (read/write) bit is 1. The data byte that follows is then neither acknowledged nor applied until the next START.
- R4: After a matching address, the 8-bit data byte is acknowledged during its ninth clock.
- R5: A data byte with bits [7:6]=00 sets diff_sel=bit 5, ocl_sel=bit 3 and mode_code=bits [2:0]. Bit 4 is reserved and has no effect on any output.
- R6: A data byte with bits [7:6] other than 00 is acknowledged, but the outputs do not change.
- R7: Outputs change only once the data acknowledge clock has ended. A STOP before that point leaves the outputs unchanged.
- R8: A START inside a byte abandons the transfer and restarts address reception. A complete transfer after that START takes effect.
- R9: sda_pull changes only while the bus clock is low.
- R10: Each transfer carries one data byte. Further bytes before the STOP are not acknowledged and do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the wire (asynchronous) |
| addr_sel | input | 1 | Address-select pin, supplies address bit 1 |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| diff_sel | output | 1 | Single-ended/differential select |
| ocl_sel | output | 1 | Output-mode select |
| mode_code | output | 3 | 3-bit mode code |

## Verification
Each result arrives a fixed number of system clocks after a bus edge. A bus edge needs two synchronizer clocks to be recognized, so sda_pull changes three clocks after the falling clock edge that opens or closes an acknowledge slot. The register outputs change three clocks after the falling edge that ends the data acknowledge. The bench holds every bus phase for twenty system clocks and samples the acknowledge level midway through the high phase of the ninth clock, well after the pull-down has settled. The scoreboard compares the register outputs ten clocks after each STOP or abort, when any update is long complete. The R9 monitor checks at every falling system edge that sda_pull only moves while the bus clock is low.

// File: rtl/i2cms_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the write-only mode-control slave.
// Assumes one register image of five significant bits.
package i2cms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting address byte
        ST_AACK,   // driving address acknowledge
        ST_DATA,   // shifting data byte
        ST_DACK,   // driving data acknowledge
        ST_HOLD    // transfer ignored until START or STOP
    } bus_state_t;

    typedef struct packed {
        logic       diff;
        logic       ocl;
        logic [2:0] mode;
    } mode_reg_t;

endpackage

// File: rtl/i2cms_line_sync.sv
`timescale 1ns/1ps
// Module: i2cms_line_sync
// Brings one asynchronous bus line into the clock domain through a
// flop chain. It presents the synchronized level and the level one
// clock older, which a neighbour uses for edge detection.
// Assumes the line idles at IDLE_VAL (bus lines idle high).
module i2cms_line_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prev
);

    logic [STAGES:0] pipe;

    // Shift the raw line through the synchronizer and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {(STAGES+1){IDLE_VAL}};
        end else begin
            pipe <= {pipe[STAGES-1:0], din};
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign prev = pipe[STAGES];

endmodule

// File: rtl/i2cms_bus_fsm.sv
`timescale 1ns/1ps
// Module: i2cms_bus_fsm
// Protocol engine. It finds START and STOP, shifts in the address
// byte and one data byte on rising bus clock edges, drives the
// acknowledge pull-down, and issues a one-clock write strobe when the
// data acknowledge clock ends.
// Assumes synchronized lines and a system clock >= 10x the bus clock.
module i2cms_bus_fsm
    import i2cms_pkg::*;
#(
    parameter int         BYTE_W  = 8,
    parameter logic [4:0] ADDR_HI = 5'b11111,
    parameter logic       ADDR_A2 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_prev,
    input  logic              sda_lvl,
    input  logic              sda_prev,
    input  logic              addr_sel,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] exp_addr;
    logic              scl_rise, scl_fall, start_c, stop_c;

    // Decode bus edges and conditions from the synchronized lines.
    always_comb begin
        scl_rise = scl_lvl & ~scl_prev;
        scl_fall = ~scl_lvl & scl_prev;
        start_c  = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_c   = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
        exp_addr = {ADDR_HI, ADDR_A2, addr_sel, 1'b0};
    end

    // Sequence the transfer: shift, acknowledge, or ignore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
        end else if (start_c) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (stop_c) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && bit_cnt < CNT_FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == CNT_FULL) begin
                        bit_cnt <= '0;
                        if (state == ST_DATA) begin
                            state    <= ST_DACK;
                            sda_pull <= 1'b1;
                        end else if (shreg == exp_addr) begin
                            state    <= ST_AACK;
                            sda_pull <= 1'b1;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_DATA;
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    // Strobe the received byte when the data acknowledge clock ends.
    always_comb begin
        wr_en   = (state == ST_DACK) && scl_fall;
        wr_data = shreg;
    end

    // R9: the pull-down only moves while the bus clock is low.
    a_r9_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    // R3: a mismatched address byte is never acknowledged.
    a_r3_no_ack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bit_cnt == CNT_FULL && shreg != exp_addr)
        |=> !sda_pull);

    // R10: no acknowledge once the one data byte is done.
    a_r10_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_pull);

    // R7: the write strobe only comes while the acknowledge is driven.
    a_r7_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_pull);

    // Bit counter never passes a full byte.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL);

endmodule

// File: rtl/i2cms_regfile.sv
`timescale 1ns/1ps
// Module: i2cms_regfile
// Register file behind the protocol engine. The top index bits of
// the written byte pick the register. Only the mode register exists,
// and writes to any other index are dropped.
// Assumes wr_en is a single-clock strobe with wr_data valid with it.
module i2cms_regfile
    import i2cms_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int IDX_W    = 2,
    parameter int MODE_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              diff_sel,
    output logic              ocl_sel,
    output logic [2:0]        mode_code
);

    localparam logic [IDX_W-1:0] MODE_SEL = IDX_W'(MODE_IDX);

    mode_reg_t        mode_q;
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = wr_data[BYTE_W-1 -: IDX_W];

    // Load the mode fields on a write aimed at the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en && wr_idx == MODE_SEL) begin
            mode_q.diff <= wr_data[5];
            mode_q.ocl  <= wr_data[3];
            mode_q.mode <= wr_data[2:0];
        end
    end

    assign diff_sel  = mode_q.diff;
    assign ocl_sel   = mode_q.ocl;
    assign mode_code = mode_q.mode;

    // R1: reset leaves the register cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0));

    // R7: the register moves only right after a write strobe.
    a_r7_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(wr_en));

    // R5: the reserved bit does not leak into the neighbouring field.
    a_r5_rsv_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4] && wr_idx == MODE_SEL)
        |=> (mode_q.ocl == $past(wr_data[3])));

endmodule

// File: rtl/i2c_mode_slave.sv
`timescale 1ns/1ps
// Module: i2c_mode_slave
// Top of the write-only control slave: it synchronizes both bus
// lines, runs the protocol engine and holds the mode register.
// Assumes the system clock is at least 10x the bus clock.
module i2c_mode_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_W      = 8,
    parameter logic [4:0] ADDR_HI     = 5'b11111,
    parameter logic       ADDR_A2     = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_sel,
    output logic       sda_pull,
    output logic       diff_sel,
    output logic       ocl_sel,
    output logic [2:0] mode_code
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_line, lvl_line, prev_line;
    logic               wr_en;
    logic [BYTE_W-1:0]  wr_data;

    assign raw_line = {sda_in, scl_in};

    // One synchronizer per bus line (index 0 clock, index 1 data).
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2cms_line_sync #(
            .STAGES   (SYNC_STAGES),
            .IDLE_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_line[g]),
            .lvl   (lvl_line[g]),
            .prev  (prev_line[g])
        );
    end

    i2cms_bus_fsm #(
        .BYTE_W  (BYTE_W),
        .ADDR_HI (ADDR_HI),
        .ADDR_A2 (ADDR_A2)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl_line[0]),
        .scl_prev (prev_line[0]),
        .sda_lvl  (lvl_line[1]),
        .sda_prev (prev_line[1]),
        .addr_sel (addr_sel),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    i2cms_regfile #(
        .BYTE_W   (BYTE_W),
        .IDX_W    (2),
        .MODE_IDX (0)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .diff_sel  (diff_sel),
        .ocl_sel   (ocl_sel),
        .mode_code (mode_code)
    );

endmodule

// File: tb/i2c_mode_slave_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: transfer tasks push expected register images,
// a monitor pops and compares them after each transfer ends.
module i2c_mode_slave_bench;

    localparam int Q = 20;  // system clocks per bus phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_pull, diff_sel, ocl_sel;
    logic [2:0] mode_code;
    wire  sda_line = m_sda & ~sda_pull;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [4:0] model = '0;
    logic [4:0] exp_q[$];
    string      req_q[$];
    event       xfer_done;

    always #2.5 clk = ~clk;

    i2c_mode_slave u_i2c_mode_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .addr_sel(addr_sel), .sda_pull(sda_pull), .diff_sel(diff_sel),
        .ocl_sel(ocl_sel), .mode_code(mode_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
        end
    endtask

    // Line level in the middle of the ninth clock: 0 means acknowledged.
    task automatic get_ack(output logic lvl);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2);
        lvl = sda_line; wq(Q/2); m_scl = 1'b0; wq(Q);
    endtask

    task automatic push_expect(input string req);
        exp_q.push_back(model);
        req_q.push_back(req);
        -> xfer_done;
        wq(40);
    endtask

    task automatic apply_model(input logic [7:0] d);
        if (d[7:6] == 2'b00) model = {d[5], d[3], d[2:0]};
    endtask

    task automatic write_xfer(input logic [7:0] a, input logic [7:0] d,
                              input logic exp_aa, input logic exp_da,
                              input string ra, input string rd, input string rv);
        logic ak;
        bus_start();
        send_bits(a, 8);
        get_ack(ak);
        check(ra, ak, !exp_aa);
        send_bits(d, 8);
        get_ack(ak);
        check(rd, ak, !exp_da);
        bus_stop();
        if (exp_da) apply_model(d);
        push_expect(rv);
    endtask

    // Monitor: compare outputs with the next expected image.
    initial begin
        forever begin
            @(xfer_done);
            wq(10);
            if (exp_q.size() > 0) begin
                automatic logic [4:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                check(r, {diff_sel, ocl_sel, mode_code}, e);
            end
        end
    end

    // R9 monitor: the pull-down may only move while the clock is low.
    initial begin
        logic prev_pull = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && sda_pull !== prev_pull) check("R9 pull moved", m_scl, 1'b0);
            prev_pull = sda_pull;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ak;
        wq(5);
        check("R1 reset outputs", {diff_sel, ocl_sel, mode_code}, 5'h00);
        check("R1 reset pull", sda_pull, 1'b0);
        rst_n = 1'b1;
        wq(10);

        // Mode writes with addr_sel low (address 0xF8).
        write_xfer(8'hF8, 8'h2D, 1, 1, "R2 addr ack", "R4 data ack", "R5 fields 0x2D");
        write_xfer(8'hF8, 8'h13, 1, 1, "R2 addr ack", "R4 data ack", "R5 D4 ignored 0x13");
        write_xfer(8'hF8, 8'h3F, 1, 1, "R2 addr ack", "R4 data ack", "R5 all ones 0x3F");
        // Unimplemented indices.
        write_xfer(8'hF8, 8'h47, 1, 1, "R6 addr ack", "R6 data ack", "R6 index 01 dropped");
        write_xfer(8'hF8, 8'hC0, 1, 1, "R6 addr ack", "R6 data ack", "R6 index 11 dropped");
        // Mismatched addresses.
        write_xfer(8'hFA, 8'h00, 0, 0, "R3 wrong A1 nack", "R3 data nack", "R3 unchanged");
        write_xfer(8'hF9, 8'h00, 0, 0, "R3 read bit nack", "R3 data nack", "R3 unchanged");
        // Address-select high.
        addr_sel = 1'b1;
        wq(10);
        write_xfer(8'hF8, 8'h01, 0, 0, "R2 old addr nack", "R3 data nack", "R3 unchanged sel1");
        write_xfer(8'hFA, 8'h01, 1, 1, "R2 sel1 ack", "R4 data ack", "R2 sel1 write");

        // STOP inside the data byte.
        bus_start(); send_bits(8'hFA, 8); get_ack(ak);
        check("R7 addr ack", ak, 1'b0);
        send_bits(8'h25, 4); bus_stop();
        push_expect("R7 stop mid byte");

        // START inside the data byte, then a full transfer.
        bus_start(); send_bits(8'hFA, 8); get_ack(ak);
        check("R8 addr ack", ak, 1'b0);
        send_bits(8'h07, 5);
        write_xfer(8'hFA, 8'h24, 1, 1, "R8 restart addr ack", "R8 data ack", "R8 restart write");

        // Two data bytes in one transfer.
        bus_start(); send_bits(8'hFA, 8); get_ack(ak);
        check("R10 addr ack", ak, 1'b0);
        send_bits(8'h06, 8); get_ack(ak);
        check("R10 first data ack", ak, 1'b0);
        apply_model(8'h06);
        send_bits(8'h07, 8); get_ack(ak);
        check("R10 second byte nack", ak, 1'b1);
        bus_stop();
        push_expect("R10 first byte only");

        // Reset after a nonzero value.
        write_xfer(8'hFA, 8'h2F, 1, 1, "R2 addr ack", "R4 data ack", "R5 fields 0x2F");
        rst_n = 1'b0;
        wq(3);
        check("R1 reset clears", {diff_sel, ocl_sel, mode_code}, 5'h00);
        check("R1 reset pull", sda_pull, 1'b0);
        rst_n = 1'b1;
        model = '0;
        wq(10);
        write_xfer(8'hFA, 8'h02, 1, 1, "R2 addr ack", "R4 data ack", "R1 works after reset");

        wq(20);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule